// File: doc/BRIEF.md
# Programming-Link Frame Receiver

This block sits behind a byte-wide serial receiver on the flash-programming link of a small controller. It watches the incoming byte stream for the start of a frame and recognises two frame shapes. The first carries a command: a command byte plus optional parameter bytes. The second carries a block of raw payload bytes. Every frame holds a length byte and a subtractive checksum. The checksum starts at zero, and each counted byte is taken away from it modulo 256. A fixed footer closes the frame.

Parameter or payload bytes are passed on one per cycle as they arrive, with a flag on the final one. When the footer arrives, the block gives a verdict on the frame. A one-byte status goes to the response generator. A separate `frame_valid` pulse marks frames that a command executor may act on. A programmable inter-byte timeout drops a frame whose sender has stalled, and the receiver then goes back to hunting for a header.

Top module: `prog_frame_rx`

## Requirements
- R1: While hunting, every byte other than 0x01 (command header) and 0x02 (data header) is ignored. Such a byte produces no payload, status or frame strobe.
- R2: A command frame has the byte sequence 0x01, LEN, COM, LEN-1 parameter bytes, SUM, 0x03. Each parameter byte appears on `pl_byte` with `pl_valid` high, in arrival order. On an accepted frame, `frame_valid` pulses with `frame_is_data`=0 and `cmd_byte`=COM, and status is 0x06. When LEN=1 no parameter strobes occur.
- R3: A data frame has the byte sequence 0x02, LEN, LEN data bytes, SUM, footer, and its data bytes stream out on `pl_byte`. Footer 0x17 means more frames follow and gives `frame_last`=0. Footer 0x03 gives `frame_last`=1. On an accepted data frame, `frame_is_data`=1.
- R4: SUM must equal (0 − LEN − COM − each parameter) mod 256 for a command frame, or (0 − LEN − each data byte) mod 256 for a data frame. On a mismatch the status is 0x07 and `frame_valid` stays low.
- R5: Only the command codes 0x13, 0x22, 0x32, 0x40, 0xA0, 0xB0, 0xC0 and 0xC5 are accepted. Any other code in a command frame with a correct checksum gives status 0x04 and no `frame_valid`. A checksum mismatch reports 0x07 even when the code is also unknown.
- R6: A LEN byte of 0x00 stands for 256. A command frame then carries 255 parameter bytes, and a data frame carries 256 data bytes.
- R7: A footer byte that is wrong for the frame type drops the frame without any status or frame strobe. The wrong bytes are 0x03 and 0x17 in any other case than the ones listed above, 0x17 after a command frame, and any third value. The next well-formed frame is then received normally.
- R8: While a frame is open, `timeout_limit` consecutive cycles without a byte drop it, and the receiver returns to hunting. A gap one cycle shorter keeps the frame. A limit of 0 turns the timeout off.
- R9: During and right after reset, all strobes (`pl_valid`, `pl_last`, `status_valid`, `frame_valid`) are low.
- R10: A byte accepted at a clock edge produces its payload strobe, or for the footer its status and frame strobes, at the following edge. `pl_last` is high only together with `pl_valid`, on the final body byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| timeout_limit | input | TMO_W | Idle cycles that abandon an open frame; 0 disables |
| frame_valid | output | 1 | One-cycle pulse: frame accepted |
| frame_is_data | output | 1 | Type of the accepted frame (1 = data frame) |
| frame_last | output | 1 | Accepted frame ended with 0x03 |
| cmd_byte | output | 8 | Command byte of the latest command frame |
| pl_valid | output | 1 | Parameter/data byte strobe |
| pl_byte | output | 8 | Parameter/data byte |
| pl_last | output | 1 | Final parameter/data byte of the frame |
| status_valid | output | 1 | Status strobe |
| status_code | output | 8 | 0x06 accepted, 0x04 unknown command, 0x07 checksum error |

## Verification
The bench sends command frames carrying all 256 command codes and checks each verdict. A classifier with a wrong table would return 0x04 for a legal code, or would raise `frame_valid` for a bad one. It sweeps short lengths and the LEN=0 case for both frame types, and it checks count, order and last flag of the streamed bytes. An off-by-one in the remaining-byte counter would treat SUM as payload or payload as SUM, and a 256 decode would end the frame after zero bytes. Corrupted checksums on an unknown code check that 0x07 takes precedence. Wrong footers, junk between frames and idle gaps of exactly limit−1 and limit cycles find designs that report dropped frames, stay out of hunt mode, or time out one cycle early or late.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int BYTE_W = 8;
    localparam int REM_W  = BYTE_W + 1;

    localparam logic [7:0] HDR_CMD = 8'h01;
    localparam logic [7:0] HDR_DAT = 8'h02;
    localparam logic [7:0] FT_END  = 8'h03;
    localparam logic [7:0] FT_MORE = 8'h17;

    typedef enum logic [7:0] {
        ST_CMD_ERR = 8'h04,
        ST_ACK     = 8'h06,
        ST_SUM_ERR = 8'h07
    } status_e;

    typedef enum logic {
        FK_CMD  = 1'b0,
        FK_DATA = 1'b1
    } frame_kind_e;

    typedef enum logic [2:0] {
        P_HUNT,
        P_LEN,
        P_COM,
        P_BODY,
        P_SUM,
        P_FOOT
    } pstate_e;

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [BYTE_W-1:0] data;
    } pl_beat_t;

    typedef struct packed {
        logic    vld;
        status_e code;
    } status_t;

    function automatic logic cmd_known(input logic [7:0] c);
        case (c)
            8'h13, 8'h22, 8'h32, 8'h40,
            8'hA0, 8'hB0, 8'hC0, 8'hC5: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/frm_csum.sv
module frm_csum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (en)    acc <= acc - din;
    end
endmodule

// File: rtl/frm_timer.sv
module frm_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] gap;

    assign expire = active && !tick && (limit != '0) && (gap == limit - ONE);

    always_ff @(posedge clk) begin
        if (rst || !active || tick || expire) gap <= '0;
        else                                  gap <= gap + ONE;
    end
endmodule

// File: rtl/frm_cmd_class.sv
module frm_cmd_class (
    input  logic [7:0] cmd,
    output logic       known
);
    import frm_pkg::*;
    always_comb known = cmd_known(cmd);
endmodule

// File: rtl/prog_frame_rx.sv
module prog_frame_rx
    import frm_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [TMO_W-1:0] timeout_limit,
    output logic             frame_valid,
    output logic             frame_is_data,
    output logic             frame_last,
    output logic [7:0]       cmd_byte,
    output logic             pl_valid,
    output logic [7:0]       pl_byte,
    output logic             pl_last,
    output logic             status_valid,
    output logic [7:0]       status_code
);
    localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

    pstate_e          state;
    frame_kind_e      kind;
    logic [REM_W-1:0] rem;
    logic [7:0]       cmd_r;
    logic             sum_ok;
    pl_beat_t         pl_q;
    status_t          st_q;
    logic             fv_q, fdata_q, flast_q;

    logic             hdr_hit, csum_clr, csum_en, foot_ok, tmo_expire, cmd_ok;
    logic [REM_W-1:0] len_full;
    logic [7:0]       acc;

    frm_csum #(.W(BYTE_W)) u_csum (
        .clk(clk), .rst(rst), .clr(csum_clr), .en(csum_en),
        .din(rx_byte), .acc(acc)
    );

    frm_timer #(.TW(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .active(state != P_HUNT), .tick(rx_valid),
        .limit(timeout_limit), .expire(tmo_expire)
    );

    frm_cmd_class u_class (.cmd(cmd_r), .known(cmd_ok));

    always_comb begin
        hdr_hit  = (rx_byte == HDR_CMD) || (rx_byte == HDR_DAT);
        csum_clr = rx_valid && (state == P_HUNT) && hdr_hit;
        csum_en  = rx_valid && ((state == P_LEN) || (state == P_COM) || (state == P_BODY));
        len_full = {rx_byte == 8'h00, rx_byte};
        foot_ok  = (rx_byte == FT_END) || ((kind == FK_DATA) && (rx_byte == FT_MORE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= P_HUNT;
            kind    <= FK_CMD;
            rem     <= '0;
            cmd_r   <= '0;
            sum_ok  <= 1'b0;
            pl_q    <= '0;
            st_q    <= '{vld: 1'b0, code: ST_ACK};
            fv_q    <= 1'b0;
            fdata_q <= 1'b0;
            flast_q <= 1'b0;
        end else begin
            pl_q.vld  <= 1'b0;
            pl_q.last <= 1'b0;
            st_q.vld  <= 1'b0;
            fv_q      <= 1'b0;
            if (tmo_expire) begin
                state <= P_HUNT;
            end else if (rx_valid) begin
                case (state)
                    P_HUNT: begin
                        if (hdr_hit) begin
                            kind  <= (rx_byte == HDR_DAT) ? FK_DATA : FK_CMD;
                            state <= P_LEN;
                        end
                    end
                    P_LEN: begin
                        if (kind == FK_CMD) begin
                            rem   <= len_full - REM_ONE;
                            state <= P_COM;
                        end else begin
                            rem   <= len_full;
                            state <= P_BODY;
                        end
                    end
                    P_COM: begin
                        cmd_r <= rx_byte;
                        state <= (rem == '0) ? P_SUM : P_BODY;
                    end
                    P_BODY: begin
                        pl_q.vld  <= 1'b1;
                        pl_q.data <= rx_byte;
                        pl_q.last <= (rem == REM_ONE);
                        rem       <= rem - REM_ONE;
                        if (rem == REM_ONE) state <= P_SUM;
                    end
                    P_SUM: begin
                        sum_ok <= (rx_byte == acc);
                        state  <= P_FOOT;
                    end
                    P_FOOT: begin
                        if (foot_ok) begin
                            st_q.vld <= 1'b1;
                            if (!sum_ok)                        st_q.code <= ST_SUM_ERR;
                            else if (kind == FK_CMD && !cmd_ok) st_q.code <= ST_CMD_ERR;
                            else                                st_q.code <= ST_ACK;
                            fv_q    <= sum_ok && ((kind == FK_DATA) || cmd_ok);
                            fdata_q <= (kind == FK_DATA);
                            flast_q <= (rx_byte == FT_END);
                        end
                        state <= P_HUNT;
                    end
                    default: state <= P_HUNT;
                endcase
            end
        end
    end

    assign frame_valid   = fv_q;
    assign frame_is_data = fdata_q;
    assign frame_last    = flast_q;
    assign cmd_byte      = cmd_r;
    assign pl_valid      = pl_q.vld;
    assign pl_byte       = pl_q.data;
    assign pl_last       = pl_q.last;
    assign status_valid  = st_q.vld;
    assign status_code   = st_q.code;

endmodule

// File: rtl/frm_rx_chk.sv
module frm_rx_chk
    import frm_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic [TMO_W-1:0] timeout_limit,
    input logic             frame_valid,
    input logic             frame_is_data,
    input logic [7:0]       cmd_byte,
    input logic             pl_valid,
    input logic             pl_last,
    input logic             status_valid,
    input logic [7:0]       status_code
);
    logic [TMO_W:0] idle_run;

    always_ff @(posedge clk) begin
        if (rst || rx_valid)        idle_run <= '0;
        else if (!(&idle_run))      idle_run <= idle_run + 1'b1;
    end

    assert_accept_is_ack_R2: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (status_valid && status_code == 8'h06));

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(pl_valid && status_valid));

    assert_code_legal_R4: assert property (@(posedge clk) disable iff (rst)
        status_valid |-> (status_code == 8'h04 || status_code == 8'h06 || status_code == 8'h07));

    assert_known_only_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame_is_data) |-> cmd_known(cmd_byte));

    assert_abandon_R8: assert property (@(posedge clk) disable iff (rst)
        (timeout_limit != '0 && idle_run >= {1'b0, timeout_limit} && rx_valid)
        |=> !(status_valid || pl_valid));

    assert_last_with_beat_R10: assert property (@(posedge clk) disable iff (rst)
        pl_last |-> pl_valid);

    assert_byte_driven_R10: assert property (@(posedge clk) disable iff (rst)
        (pl_valid || status_valid) |-> $past(rx_valid));

endmodule

bind prog_frame_rx frm_rx_chk #(.TMO_W(TMO_W)) i_frm_rx_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .timeout_limit(timeout_limit),
    .frame_valid(frame_valid), .frame_is_data(frame_is_data), .cmd_byte(cmd_byte),
    .pl_valid(pl_valid), .pl_last(pl_last), .status_valid(status_valid),
    .status_code(status_code)
);

// File: tb/test_prog_frame_rx.sv
`timescale 1ns/1ps
module test_prog_frame_rx;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic [TMO_W-1:0] tmo = '0;
    logic             frame_valid, frame_is_data, frame_last, pl_valid, pl_last, status_valid;
    logic [7:0]       cmd_byte, pl_byte, status_code;

    prog_frame_rx #(.TMO_W(TMO_W)) i_prog_frame_rx (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .timeout_limit(tmo), .frame_valid(frame_valid), .frame_is_data(frame_is_data),
        .frame_last(frame_last), .cmd_byte(cmd_byte), .pl_valid(pl_valid),
        .pl_byte(pl_byte), .pl_last(pl_last), .status_valid(status_valid),
        .status_code(status_code)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    int pl_n, last_n, last_pos, fr_n, st_n, exp_nb;
    logic [7:0] rcv [0:299];
    logic [7:0] expb [0:299];
    logic [7:0] st_m, fr_cmd_m;
    logic fr_data_m, fr_last_m;

    always @(negedge clk) begin
        if (!rst) begin
            if (pl_valid) begin
                if (pl_n < 300) rcv[pl_n] = pl_byte;
                if (pl_last) begin last_n++; last_pos = pl_n; end
                pl_n++;
            end
            if (status_valid) begin st_n++; st_m = status_code; end
            if (frame_valid) begin
                fr_n++; fr_cmd_m = cmd_byte; fr_data_m = frame_is_data; fr_last_m = frame_last;
            end
        end
    end

    function automatic bit known(input logic [7:0] c);
        return c == 8'h13 || c == 8'h22 || c == 8'h32 || c == 8'h40 ||
               c == 8'hA0 || c == 8'hB0 || c == 8'hC0 || c == 8'hC5;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        pl_n = 0; last_n = 0; last_pos = -1; fr_n = 0; st_n = 0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input bit is_data, input logic [7:0] lenf, input logic [7:0] com,
                              input int seed, input bit bad_sum, input logic [7:0] foot);
        int nb;
        logic [7:0] s;
        nb = (lenf == 8'h00) ? 256 : int'(lenf);
        if (!is_data) nb = nb - 1;
        s = 8'h00 - lenf;
        put(is_data ? 8'h02 : 8'h01);
        put(lenf);
        if (!is_data) begin put(com); s = s - com; end
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * 13);
            expb[i] = b;
            s = s - b;
            put(b);
        end
        if (bad_sum) s = s ^ 8'h5A;
        put(s);
        put(foot);
        exp_nb = nb;
        idle(2);
    endtask

    task automatic chk_payload(input string tag);
        int bad;
        bad = 0;
        chk({tag, " payload count"}, pl_n, exp_nb);
        chk({tag, " last count"}, last_n, (exp_nb > 0) ? 1 : 0);
        if (exp_nb > 0) chk({tag, " last position"}, last_pos, exp_nb - 1);
        for (int i = 0; i < exp_nb && i < 300; i++) if (rcv[i] !== expb[i]) bad++;
        chk({tag, " payload bytes mismatched"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R9: strobes low in reset
        chk("R9 reset strobes", {pl_valid, pl_last, status_valid, frame_valid}, 0);
        rst = 1'b0;
        idle(2);
        chk("R9 after reset strobes", {pl_valid, pl_last, status_valid, frame_valid}, 0);

        // R1: junk while hunting
        clear_mon();
        put(8'h00); put(8'h03); put(8'h17); put(8'hFF); put(8'h40); put(8'h13);
        idle(3);
        chk("R1 junk status", st_n, 0);
        chk("R1 junk payload", pl_n, 0);
        chk("R1 junk frame", fr_n, 0);

        // R5 / R2: all command codes
        for (int c = 0; c < 256; c++) begin
            clear_mon();
            send_frame(1'b0, 8'd3, 8'(c), c, 1'b0, 8'h03);
            chk("R5 sweep status", int'(st_m), known(8'(c)) ? 6 : 4);
            chk("R5 sweep status count", st_n, 1);
            chk("R5 sweep frame count", fr_n, known(8'(c)) ? 1 : 0);
            chk("R2 sweep payload count", pl_n, 2);
        end

        // R2 / R10: command lengths 1..12
        for (int l = 1; l <= 12; l++) begin
            clear_mon();
            send_frame(1'b0, 8'(l), 8'h40, l * 5, 1'b0, 8'h03);
            chk_payload("R10 cmd len");
            chk("R2 cmd accepted", fr_n, 1);
            chk("R2 cmd byte", int'(fr_cmd_m), 8'h40);
            chk("R2 cmd kind", int'(fr_data_m), 0);
            chk("R2 cmd status", int'(st_m), 6);
        end

        // R3: data lengths 1..12, both footers
        for (int l = 1; l <= 12; l++) begin
            clear_mon();
            send_frame(1'b1, 8'(l), 8'h00, l * 3 + 1, 1'b0, (l % 2 == 0) ? 8'h03 : 8'h17);
            chk_payload("R3 data len");
            chk("R3 data accepted", fr_n, 1);
            chk("R3 data kind", int'(fr_data_m), 1);
            chk("R3 data last flag", int'(fr_last_m), (l % 2 == 0) ? 1 : 0);
            chk("R3 data status", int'(st_m), 6);
        end

        // R6: LEN 0 means 256
        clear_mon();
        send_frame(1'b0, 8'h00, 8'hB0, 9, 1'b0, 8'h03);
        chk_payload("R6 cmd len0");
        chk("R6 cmd len0 status", int'(st_m), 6);
        clear_mon();
        send_frame(1'b1, 8'h00, 8'h00, 77, 1'b0, 8'h17);
        chk_payload("R6 data len0");
        chk("R6 data len0 frame", fr_n, 1);

        // R4: checksum errors
        clear_mon();
        send_frame(1'b0, 8'd4, 8'h40, 21, 1'b1, 8'h03);
        chk("R4 bad sum status", int'(st_m), 7);
        chk("R4 bad sum frame", fr_n, 0);
        clear_mon();
        send_frame(1'b1, 8'd5, 8'h00, 33, 1'b1, 8'h03);
        chk("R4 data bad sum status", int'(st_m), 7);
        chk("R4 data bad sum frame", fr_n, 0);
        // R5: checksum error wins over unknown code
        clear_mon();
        send_frame(1'b0, 8'd2, 8'h99, 4, 1'b1, 8'h03);
        chk("R5 precedence status", int'(st_m), 7);

        // R7: wrong footers
        clear_mon();
        send_frame(1'b0, 8'd3, 8'h22, 8, 1'b0, 8'h17);
        chk("R7 cmd footer 0x17 status count", st_n, 0);
        chk("R7 cmd footer 0x17 frame", fr_n, 0);
        clear_mon();
        send_frame(1'b1, 8'd3, 8'h00, 8, 1'b0, 8'h55);
        chk("R7 data footer 0x55 status count", st_n, 0);
        clear_mon();
        send_frame(1'b0, 8'd1, 8'hC5, 0, 1'b0, 8'h03);
        chk("R7 recovery status count", st_n, 1);
        chk("R7 recovery status", int'(st_m), 6);
        chk("R2 len1 no payload", pl_n, 0);

        // R8: timeout
        tmo = 16'd5;
        idle(1);
        clear_mon();
        put(8'h01); put(8'h03); idle(4);
        put(8'h13); put(8'h20); idle(4); put(8'h30);
        put(8'(8'h00 - 8'h03 - 8'h13 - 8'h20 - 8'h30)); put(8'h03);
        idle(2);
        chk("R8 gap limit-1 kept status count", st_n, 1);
        chk("R8 gap limit-1 kept status", int'(st_m), 6);
        clear_mon();
        put(8'h01); put(8'h03); idle(5);
        send_frame(1'b0, 8'd3, 8'h22, 50, 1'b0, 8'h03);
        chk("R8 gap limit dropped status count", st_n, 1);
        chk("R8 gap limit dropped status", int'(st_m), 6);
        chk("R8 gap limit dropped payload", pl_n, 2);
        tmo = '0;
        idle(1);
        clear_mon();
        put(8'h01); put(8'h02); idle(40);
        put(8'hA0); put(8'h11);
        put(8'(8'h00 - 8'h02 - 8'hA0 - 8'h11)); put(8'h03);
        idle(2);
        chk("R8 disabled status", int'(st_m), 6);
        chk("R8 disabled status count", st_n, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule